// File: doc/BRIEF.md
# Clock Output Mode Controller

This block sits beside a differential clock source and decides, every cycle, what the true and complement clock pins should carry. It supplies a drive code for each pin (phase-aligned clock, raw PLL clock, reference clock, a static level, or high impedance), plus an on/off signal for the clock source. It also reports which of its three operating states it is in. The PLL, the phase aligner and the pad drivers are outside the block and act on these codes.

Two layers of control decide the result. A two-bit test-mode select picks the clock source. The select is latched only while the block is powered down and is frozen otherwise. A three-state power/stop machine, fed by the asynchronous active-low power-down and clock-stop inputs, can override the select. These two inputs pass through a two-flop synchronizer before the state register samples them.

Top module: `clkout_mode_ctrl`

## Requirements
- R1: While the synchronized power-down input is low, the state output reads 00 (powered down) and the source-enable output is 0. Both pin codes read 001 (driven low). This holds whatever the stop input and the select are.
- R2: With power-down high and stop low, the state reads 01 (clock stopped) and the source-enable output is 1. The true pin code reads 001 (low) and the complement pin code reads 010 (high), for every select value.
- R3: With power-down and stop both high, the state reads 10 (running). With a latched select of 00, both pin codes read 011 (phase-aligned clock and its complement).
- R4: In the running state with a latched select of 01, both pin codes read 000 (high impedance).
- R5: In the running state with a latched select of 10, both pin codes read 100 (PLL clock and its complement, no phase alignment).
- R6: In the running state with a latched select of 11, both pin codes read 101 (reference clock and its complement).
- R7: The select input is latched on every rising edge at which the state is 00, and the latched value is shown on the mode output. A change to the select in any other state has no effect on the mode output or the pin codes until the block next passes through the powered-down state.
- R8: A change on the power-down or stop input that is set up before rising edge k shows on the state output after edge k+2 and not earlier. This is two synchronizer flops followed by the state register.
- R9: While reset is asserted, the state is 00, both pin codes are 001, the mode output is 00 and the source is off. After reset is released, the block moves to the state that the present inputs call for.
- R10: The state output never takes the value 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_dn_n | input | 1 | Asynchronous power-down request, active low |
| stop_n | input | 1 | Asynchronous clock-stop request, active low |
| mode_sel | input | 2 | Test-mode select, latched only while powered down |
| state_o | output | 2 | Operating state: 00 powered down, 01 stopped, 10 running |
| mode_o | output | 2 | Latched test-mode select |
| src_on_o | output | 1 | Clock source enable |
| true_code_o | output | 3 | True pin drive code: 000 Hi-Z, 001 low, 010 high, 011 phase-aligned, 100 PLL, 101 reference |
| comp_code_o | output | 3 | Complement pin drive code, same encoding, complement sense of the clock |

## Verification
A table drives every select value into the running state, so the four source codes are told apart from each other. The same table pairs selects with the stopped and powered-down states, which shows that those states override any select, including the Hi-Z select. Directed sequences count the edges from a control change to the state change, separately for reset release and for a stop request. Another sequence changes the select while running and confirms it takes effect only after the block passes through power-down.

// File: rtl/clkout_mode_ctrl.sv
module clkout_mode_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_dn_n,
  input  logic       stop_n,
  input  logic [1:0] mode_sel,
  output logic [1:0] state_o,
  output logic [1:0] mode_o,
  output logic       src_on_o,
  output logic [2:0] true_code_o,
  output logic [2:0] comp_code_o
);

  localparam logic [1:0] ST_PD   = 2'b00;
  localparam logic [1:0] ST_STOP = 2'b01;
  localparam logic [1:0] ST_RUN  = 2'b10;

  localparam logic [2:0] DRV_HIZ  = 3'd0;
  localparam logic [2:0] DRV_LOW  = 3'd1;
  localparam logic [2:0] DRV_HIGH = 3'd2;
  localparam logic [2:0] DRV_PA   = 3'd3;
  localparam logic [2:0] DRV_PLL  = 3'd4;
  localparam logic [2:0] DRV_REF  = 3'd5;

  logic [SYNC_STAGES-1:0] pd_sync, st_sync;
  logic [1:0] state_q, state_d, mode_q;
  logic       pd_ok, st_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_sync <= '0;
      st_sync <= '0;
    end else begin
      pd_sync <= {pd_sync[SYNC_STAGES-2:0], pwr_dn_n};
      st_sync <= {st_sync[SYNC_STAGES-2:0], stop_n};
    end
  end

  assign pd_ok = pd_sync[SYNC_STAGES-1];
  assign st_ok = st_sync[SYNC_STAGES-1];

  always_comb begin
    if (!pd_ok)      state_d = ST_PD;
    else if (!st_ok) state_d = ST_STOP;
    else             state_d = ST_RUN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_PD;
      mode_q  <= 2'b00;
    end else begin
      state_q <= state_d;
      if (state_q == ST_PD) mode_q <= mode_sel;
    end
  end

  always_comb begin
    true_code_o = DRV_LOW;
    comp_code_o = DRV_LOW;
    case (state_q)
      ST_STOP: begin
        true_code_o = DRV_LOW;
        comp_code_o = DRV_HIGH;
      end
      ST_RUN: begin
        case (mode_q)
          2'b00:   begin true_code_o = DRV_PA;  comp_code_o = DRV_PA;  end
          2'b01:   begin true_code_o = DRV_HIZ; comp_code_o = DRV_HIZ; end
          2'b10:   begin true_code_o = DRV_PLL; comp_code_o = DRV_PLL; end
          default: begin true_code_o = DRV_REF; comp_code_o = DRV_REF; end
        endcase
      end
      default: ;
    endcase
  end

  assign state_o  = state_q;
  assign mode_o   = mode_q;
  assign src_on_o = (state_q != ST_PD);

  // R1
  pd_forces_gnd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_ok |=> (state_o == ST_PD) && !src_on_o && (true_code_o == DRV_LOW) && (comp_code_o == DRV_LOW));

  // R2
  stop_holds_levels_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_ok && !st_ok) |=> src_on_o && (true_code_o == DRV_LOW) && (comp_code_o == DRV_HIGH));

  // R7
  mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) != ST_PD) |-> $stable(mode_o));

  // R8
  run_follows_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_ok && st_ok) |=> (state_o == ST_RUN));

  // R10
  legal_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_o != 2'b11);

endmodule

// File: tb/clkout_mode_ctrl_tb.sv
module clkout_mode_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_dn_n = 1'b1;
  logic stop_n = 1'b1;
  logic [1:0] mode_sel = 2'b10;
  logic [1:0] state_o, mode_o;
  logic src_on_o;
  logic [2:0] true_code_o, comp_code_o;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  clkout_mode_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_dn_n(pwr_dn_n), .stop_n(stop_n),
    .mode_sel(mode_sel), .state_o(state_o), .mode_o(mode_o),
    .src_on_o(src_on_o), .true_code_o(true_code_o), .comp_code_o(comp_code_o)
  );

  // {sel[1:0], pd_n, stop_n, state[1:0], true[2:0], comp[2:0]}
  localparam int NVEC = 8;
  localparam logic [11:0] VEC [NVEC] = '{
    {2'b00, 1'b1, 1'b1, 2'b10, 3'd3, 3'd3},
    {2'b01, 1'b1, 1'b1, 2'b10, 3'd0, 3'd0},
    {2'b10, 1'b1, 1'b1, 2'b10, 3'd4, 3'd4},
    {2'b11, 1'b1, 1'b1, 2'b10, 3'd5, 3'd5},
    {2'b00, 1'b1, 1'b0, 2'b01, 3'd1, 3'd2},
    {2'b11, 1'b1, 1'b0, 2'b01, 3'd1, 3'd2},
    {2'b10, 1'b0, 1'b1, 2'b00, 3'd1, 3'd1},
    {2'b01, 1'b0, 1'b0, 2'b00, 3'd1, 3'd1}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #100us;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    settle(3);
    chk("R9 reset state", state_o, 0);
    chk("R9 reset true", true_code_o, 1);
    chk("R9 reset comp", comp_code_o, 1);
    chk("R9 reset mode", mode_o, 0);
    chk("R9 reset src", src_on_o, 0);
    rst_n = 1'b1;
    settle(2);
    chk("R8 state before third edge", state_o, 0);
    settle(1);
    chk("R9 R8 state after third edge", state_o, 2);
    chk("R7 mode latched in power-down", mode_o, 2);

    // R7: select change while running is ignored
    mode_sel = 2'b11;
    settle(6);
    chk("R7 mode frozen", mode_o, 2);
    chk("R7 true code frozen", true_code_o, 4);
    pwr_dn_n = 1'b0;
    settle(5);
    pwr_dn_n = 1'b1;
    settle(5);
    chk("R7 mode after power-down", mode_o, 3);
    chk("R7 true code after power-down", true_code_o, 5);

    // R8: stop latency
    stop_n = 1'b0;
    settle(2);
    chk("R8 stop not yet seen", state_o, 2);
    settle(1);
    chk("R8 stop seen", state_o, 1);

    for (int i = 0; i < NVEC; i++) begin
      logic [11:0] v;
      v = VEC[i];
      pwr_dn_n = 1'b0;
      stop_n = 1'b0;
      mode_sel = v[11:10];
      settle(5);
      pwr_dn_n = v[9];
      stop_n = v[8];
      settle(5);
      chk("R1-R6 table state (R1 R2 R3)", state_o, v[7:6]);
      chk("R3 R4 R5 R6 table true code", true_code_o, v[5:3]);
      chk("R2 R4 R5 R6 table comp code", comp_code_o, v[2:0]);
      chk("R7 table mode", mode_o, v[11:10]);
      chk("R1 table src", src_on_o, (v[7:6] != 2'b00) ? 1 : 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule